// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a set of raw interrupt request lines into a vector of pending requests for a downstream priority resolver. Each line is sampled on every clock. A per-line trigger-mode bit decides how the line is sensed. In edge mode, a rising level latches a request that stays set until it is acknowledged. In level mode, the request follows the line and ignores acknowledges.

The block keeps a remembered copy of each line's previous level so that it can find rising edges. A byte-wide trigger-mode register is written through a write port and reads back continuously. A fixed per-instance mask limits which lines may ever be level-sensed, so a line outside the mask stays edge-sensed whatever value is written. A software initialization strobe clears the requests and the remembered levels but keeps the trigger modes. Only the hardware reset clears the trigger modes.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous hardware reset (`rst` high at a clock edge) clears `pending` and `trig_mode` to all zeros at that edge.
- R2: For a line whose trigger-mode bit is 0 (edge), the line going high while its remembered level is low sets its `pending` bit at the next clock edge. The remembered level then becomes high.
- R3: For an edge line, holding the level high does not set the request again after it was cleared. A low level clears the remembered level and leaves the `pending` bit unchanged, so a later high level sets the request again.
- R4: For a line whose trigger-mode bit is 1 (level), the `pending` bit after each clock edge equals the line level sampled at that edge.
- R5: An acknowledge (`ack_valid` high, line number on `ack_idx`) clears the `pending` bit of an edge line at the next edge. An acknowledge to a level line has no effect.
- R6: If an acknowledge and a new rising edge arrive on the same edge line in the same cycle, the `pending` bit stays set.
- R7: A write (`mode_wr_en` high) loads `trig_mode` with `mode_wr_data & LEVEL_MASK` at the next edge. Bits outside `LEVEL_MASK` always read 0.
- R8: `init_clr` high clears every `pending` bit and every remembered level at the next edge and leaves `trig_mode` unchanged. A line still high afterwards is seen as a new edge.
- R9: An acknowledge changes only the line selected by `ack_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| init_clr | input | 1 | Software initialization: clears requests and remembered levels |
| line_in | input | NUM_LINES | Raw request levels, sampled every clock |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | NUM_LINES | Trigger-mode write value, 1 = level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Line number being acknowledged |
| trig_mode | output | NUM_LINES | Current trigger-mode register |
| pending | output | NUM_LINES | Pending request vector |

## Verification
The assertions assume that `line_in`, the strobes and the write data are stable and known at each rising clock edge. They also assume that nothing is checked in the cycles before the first reset. The bench drives every input only on the falling edge and asserts reset in the very first cycle, so every sampled value is settled. The vectors are ordered to exercise each trigger mode in turn and the initialization strobe.

// File: rtl/irl_pkg.sv
package irl_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic req;
        logic prev;
    } line_state_t;

    localparam line_state_t LINE_IDLE = '{req: 1'b0, prev: 1'b0};

    // Next state of one request line for one sample.
    function automatic line_state_t line_next(
        input line_state_t cur,
        input logic        level,
        input trig_e       mode,
        input logic        ack
    );
        line_state_t nxt;
        logic        rise;
        nxt  = cur;
        rise = level & ~cur.prev;
        if (mode == TRIG_LEVEL) begin
            nxt.req  = level;
            nxt.prev = level;
        end else begin
            nxt.prev = level;
            if (rise)
                nxt.req = 1'b1;
            else if (ack)
                nxt.req = 1'b0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irl_mode_reg.sv
module irl_mode_reg #(
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]   LEVEL_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_data & LEVEL_MASK;
    end

endmodule

// File: rtl/irl_ack_decode.sv
module irl_ack_decode #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] ack_hit
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        assign ack_hit[g] = ack_valid && (ack_idx == IDX_W'(g));
    end

endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
    import irl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_clr,
    input  logic level_in,
    input  logic mode_bit,
    input  logic ack_hit,
    output logic req_out
);

    line_state_t st_q;
    line_state_t st_d;
    trig_e       mode;

    assign mode = trig_e'(mode_bit);

    always_comb begin
        st_d = line_next(st_q, level_in, mode, ack_hit);
        if (init_clr)
            st_d = LINE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= LINE_IDLE;
        else
            st_q <= st_d;
    end

    assign req_out = st_q.req;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] LEVEL_MASK = 8'hF8,
    localparam int                  IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_clr,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 mode_wr_en,
    input  logic [NUM_LINES-1:0] mode_wr_data,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] trig_mode,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] ack_hit;

    irl_mode_reg #(
        .NUM_LINES (NUM_LINES),
        .LEVEL_MASK(LEVEL_MASK)
    ) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mode_wr_en),
        .wr_data(mode_wr_data),
        .mode_q (trig_mode)
    );

    irl_ack_decode #(
        .NUM_LINES(NUM_LINES)
    ) u_ack (
        .ack_valid(ack_valid),
        .ack_idx  (ack_idx),
        .ack_hit  (ack_hit)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irl_line_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .init_clr(init_clr),
            .level_in(line_in[g]),
            .mode_bit(trig_mode[g]),
            .ack_hit (ack_hit[g]),
            .req_out (pending[g])
        );
    end

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] LEVEL_MASK = 8'hF8,
    localparam int                  IDX_W      = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 init_clr,
    input logic [NUM_LINES-1:0] line_in,
    input logic                 mode_wr_en,
    input logic [NUM_LINES-1:0] mode_wr_data,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_idx,
    input logic [NUM_LINES-1:0] trig_mode,
    input logic [NUM_LINES-1:0] pending
);

    logic seen_rst = 1'b0;
    always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!seen_rst)
        rst |=> (pending == '0) && (trig_mode == '0)); // R1

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        mode_wr_en |=> trig_mode == ($past(mode_wr_data) & LEVEL_MASK)); // R7

    AST_MODE_OUTSIDE_MASK: assert property (@(posedge clk) disable iff (!seen_rst)
        (trig_mode & ~LEVEL_MASK) == '0); // R7

    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        init_clr |=> pending == '0); // R8

    AST_INIT_KEEP_MODE: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (init_clr && !mode_wr_en) |=> $stable(trig_mode)); // R8

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ln
        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (trig_mode[g] && !init_clr) |=> pending[g] == $past(line_in[g])); // R4

        AST_EDGE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (!trig_mode[g] && !pending[g] && !line_in[g]) |=> !pending[g]); // R2

        AST_OTHER_ACK: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (!trig_mode[g] && pending[g] && !init_clr &&
             !(ack_valid && ack_idx == IDX_W'(g))) |=> pending[g]); // R9
    end

endmodule

bind irq_req_latch irq_req_latch_chk #(
    .NUM_LINES (NUM_LINES),
    .LEVEL_MASK(LEVEL_MASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_clr    (init_clr),
    .line_in     (line_in),
    .mode_wr_en  (mode_wr_en),
    .mode_wr_data(mode_wr_data),
    .ack_valid   (ack_valid),
    .ack_idx     (ack_idx),
    .trig_mode   (trig_mode),
    .pending     (pending)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;

    localparam int   CLK_PERIOD = 10;
    localparam int   NL         = 8;
    localparam logic [7:0] MASK = 8'hF8;
    localparam int   NV         = 20;

    // {rst, init, line[8], wen, wdata[8], ack, idx[3], exp_pending[8], exp_mode[8]}
    localparam logic [38:0] VECS [0:NV-1] = '{
        {1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,3'd0,8'h00,8'h00}, // 0  R1 reset
        {1'b0,1'b0,8'h01,1'b0,8'h00,1'b0,3'd0,8'h01,8'h00}, // 1  R2 rise
        {1'b0,1'b0,8'h01,1'b0,8'h00,1'b1,3'd0,8'h00,8'h00}, // 2  R5 ack edge
        {1'b0,1'b0,8'h01,1'b0,8'h00,1'b0,3'd0,8'h00,8'h00}, // 3  R3 held high
        {1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,3'd0,8'h00,8'h00}, // 4  R3 low
        {1'b0,1'b0,8'h01,1'b0,8'h00,1'b0,3'd0,8'h01,8'h00}, // 5  R3 re-edge
        {1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,3'd0,8'h01,8'h00}, // 6  R3 low keeps
        {1'b0,1'b0,8'h00,1'b1,8'hFF,1'b0,3'd0,8'h01,8'hF8}, // 7  R7 masked
        {1'b0,1'b0,8'h10,1'b0,8'h00,1'b0,3'd0,8'h11,8'hF8}, // 8  R4 level high
        {1'b0,1'b0,8'h10,1'b0,8'h00,1'b1,3'd4,8'h11,8'hF8}, // 9  R5 ack level
        {1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,3'd0,8'h01,8'hF8}, // 10 R4 level drop
        {1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,3'd0,8'h00,8'hF8}, // 11 R5 ack
        {1'b0,1'b0,8'h01,1'b0,8'h00,1'b1,3'd0,8'h01,8'hF8}, // 12 R6 ack+edge
        {1'b0,1'b0,8'h21,1'b0,8'h00,1'b1,3'd2,8'h21,8'hF8}, // 13 R9 ack idle
        {1'b0,1'b0,8'h03,1'b0,8'h00,1'b0,3'd0,8'h03,8'hF8}, // 14 R4 R2
        {1'b0,1'b0,8'h03,1'b0,8'h00,1'b1,3'd1,8'h01,8'hF8}, // 15 R9 single
        {1'b0,1'b1,8'h03,1'b0,8'h00,1'b0,3'd0,8'h00,8'hF8}, // 16 R8 init
        {1'b0,1'b0,8'h03,1'b0,8'h00,1'b0,3'd0,8'h03,8'hF8}, // 17 R8 re-edge
        {1'b1,1'b0,8'h03,1'b0,8'h00,1'b0,3'd0,8'h00,8'h00}, // 18 R1 reset
        {1'b0,1'b0,8'h00,1'b1,8'h07,1'b0,3'd0,8'h00,8'h00}  // 19 R7 outside mask
    };

    logic          clk = 1'b0;
    logic          rst, init_clr, mode_wr_en, ack_valid;
    logic [NL-1:0] line_in, mode_wr_data, trig_mode, pending;
    logic [2:0]    ack_idx;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_latch #(.NUM_LINES(NL), .LEVEL_MASK(MASK)) u_dut (
        .clk(clk), .rst(rst), .init_clr(init_clr), .line_in(line_in),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .ack_valid(ack_valid), .ack_idx(ack_idx),
        .trig_mode(trig_mode), .pending(pending)
    );

    task automatic drive(input logic r, input logic ic, input logic [7:0] ln,
                         input logic we, input logic [7:0] wd,
                         input logic av, input logic [2:0] ai);
        rst = r; init_clr = ic; line_in = ln;
        mode_wr_en = we; mode_wr_data = wd; ack_valid = av; ack_idx = ai;
    endtask

    task automatic check(input string req, input logic [7:0] ep, input logic [7:0] em);
        n_checks++;
        if (pending !== ep || trig_mode !== em) begin
            n_fail++;
            $display("FAIL %s: pending=%h mode=%h expected pending=%h mode=%h",
                     req, pending, trig_mode, ep, em);
        end
    endtask

    // drive on falling edge, let one rising edge pass, check on next falling edge
    task automatic step_check(input string req, input logic [7:0] ep, input logic [7:0] em);
        @(posedge clk);
        @(negedge clk);
        check(req, ep, em);
    endtask

    initial begin
        drive(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VECS[i];
            drive(v[38], v[37], v[36:29], v[28], v[27:20], v[19], v[18:16]);
            step_check($sformatf("vector %0d", i), v[15:8], v[7:0]);
        end

        // R8: level line held high through init, mode survives
        drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hF0, 1'b0, 3'd0);
        step_check("R7 write F0", 8'h00, 8'hF0);
        drive(1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 1'b0, 3'd0);
        step_check("R4 level line 7", 8'h80, 8'hF0);
        drive(1'b0, 1'b1, 8'h80, 1'b0, 8'h00, 1'b0, 3'd0);
        step_check("R8 init clears level req", 8'h00, 8'hF0);
        drive(1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 1'b0, 3'd0);
        step_check("R8 level req returns", 8'h80, 8'hF0);
        // R5: ack to level line 7 ignored while high
        drive(1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 1'b1, 3'd7);
        step_check("R5 level ack ignored", 8'h80, 8'hF0);
        // R2 R9: edge line 0 rise while level line 7 high; ack line 7 leaves line 0
        drive(1'b0, 1'b0, 8'h81, 1'b0, 8'h00, 1'b1, 3'd7);
        step_check("R9 ack other line", 8'h81, 8'hF0);
        // R6: ack line 0 when no new edge clears it
        drive(1'b0, 1'b0, 8'h81, 1'b0, 8'h00, 1'b1, 3'd0);
        step_check("R5 ack without edge", 8'h80, 8'hF0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule